// File: doc/BRIEF.md
# GPIO Controller with Grouped Interrupts

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins. Every pin has its own 32-bit configuration word. The word holds a data bit, a three-bit operating mode, a peripheral-function select, a lock bit, a three-bit interrupt group number and several pad fields (pull, drive strength, input enable, Schmitt). The pad fields are stored and read back but have no effect on the logic. The mode field selects one of three behaviours for the pin: driving its data bit, acting as a plain input, or acting as an input that raises one of five kinds of interrupt trigger.

Pad inputs pass through a two-flop synchronizer. Trigger events are recorded in the pending bank of the group that the pin's group field names. Software acknowledges an event by writing 1 to its pending bit. Each group drives its own registered, active-high interrupt line. A pin's interrupt is masked by setting its mode to "input, interrupts off" and unmasked by restoring the trigger mode; there is no separate mask register. Access uses a simple single-cycle register bus with full-word writes and registered read data.

Top module: `gpio_grp_ctrl`

## Requirements
- R1: After reset every configuration word reads 0x0000000E (mode 7, all other fields zero), every irq_out line is low and every pad_oe bit is low.
- R2: With function select (bits 6:5) equal to 0 and mode (bits 3:1) equal to 1, pad_oe is high, pad_out equals the stored data bit 0, and a read of bit 0 returns the stored data bit.
- R3: In any mode other than 1, pad_oe is low (function 0), and a read of bit 0 returns the pin level after a two-flop synchronizer rather than the stored data bit.
- R4: A function select f in 1..3 drives pad_out and pad_oe from alt_out and alt_oe bit (f-1)*NUM_PINS+p. alt_in at that same bit carries the synchronized pin level, and it is 0 for every function that is not selected.
- R5: Mode 4 sets the pin's pending bit once per rising edge, mode 5 once per falling edge, and mode 6 once per edge of either direction. A steady level after an acknowledged edge leaves the bit clear.
- R6: Mode 2 (high level) and mode 3 (low level) set the pending bit on every cycle the level condition holds. An acknowledge write therefore leaves the bit set while the condition persists, and clears it once the condition has gone.
- R7: Modes 0, 1 and 7 never set a pending bit. Changing a pin to mode 7 masks its interrupt.
- R8: An event is recorded only in the pending bank of the group held in bits 18:16. A group number at or above NUM_GROUPS records nothing.
- R9: The pending word for group g and pins 32k..32k+31 is at byte address 0x800 + 0x40*g + 4*k, with pin p at bit p mod 32. The configuration word of pin p is at byte address 4*p.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set.
- R11: irq_out[g] is the OR of group g's pending bits, registered one cycle later.
- R12: Once a configuration word has lock (bit 21) set, writes to that word are ignored until reset.
- R13: Bits 31:1 of a configuration word read back exactly as written, including pull, drive, input enable, Schmitt and group fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| alt_out | input | 3*NUM_PINS | Peripheral output values, function-major |
| alt_oe | input | 3*NUM_PINS | Peripheral output enables, function-major |
| alt_in | output | 3*NUM_PINS | Synchronized pin level to the selected peripheral |
| irq_out | output | NUM_GROUPS | Per-group interrupt lines |

## Verification
The assertions assume that bus writes are full words and that pad inputs may change on any cycle. They also assume that the mode of a pin can be rewritten while that pin is active. The edge-once property therefore allows a second event only when the mode itself has just changed. The bench drives pads and bus signals only on falling clock edges. It holds each pad level for several cycles before it reads pending state, so the synchronizer latency is always covered. It changes a pin's mode only while that pin's pad is steady, so no spurious edge is created.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;

  localparam int ADDR_W     = 12;
  localparam int WORD_W     = 32;
  localparam int ALT_FUNCS  = 3;

  localparam int BIT_DATA   = 0;
  localparam int BIT_LOCK   = 21;
  localparam int MODE_LSB   = 1;
  localparam int FUNC_LSB   = 5;
  localparam int GRP_LSB    = 16;

  localparam logic [WORD_W-1:0] CFG_RESET = 32'h0000_000E;

  typedef enum logic [2:0] {
    MODE_RSVD  = 3'd0,
    MODE_DRIVE = 3'd1,
    MODE_HIGH  = 3'd2,
    MODE_LOW   = 3'd3,
    MODE_RISE  = 3'd4,
    MODE_FALL  = 3'd5,
    MODE_BOTH  = 3'd6,
    MODE_QUIET = 3'd7
  } pin_mode_e;

  function automatic pin_mode_e cfg_mode(input logic [WORD_W-1:0] w);
    return pin_mode_e'(w[MODE_LSB +: 3]);
  endfunction

  function automatic logic [1:0] cfg_func(input logic [WORD_W-1:0] w);
    return w[FUNC_LSB +: 2];
  endfunction

  function automatic logic [2:0] cfg_group(input logic [WORD_W-1:0] w);
    return w[GRP_LSB +: 3];
  endfunction

  function automatic logic cfg_locked(input logic [WORD_W-1:0] w);
    return w[BIT_LOCK];
  endfunction

  // Trigger decision from mode, current synchronized level and prior level.
  function automatic logic trig_hit(input pin_mode_e m, input logic lv, input logic lp);
    case (m)
      MODE_HIGH: return lv;
      MODE_LOW:  return !lv;
      MODE_RISE: return lv && !lp;
      MODE_FALL: return !lv && lp;
      MODE_BOTH: return lv ^ lp;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] level_prev
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= '0;
      level      <= '0;
      level_prev <= '0;
    end else begin
      meta_q     <= raw_in;
      level      <= meta_q;
      level_prev <= level;
    end
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W   = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [WORD_W-1:0]                wr_data,
  output logic [NUM_PINS-1:0][WORD_W-1:0]  cfg
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_word
    logic hit;
    assign hit = wr_en && (32'(wr_idx) == p) && !cfg_locked(cfg[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg[p] <= CFG_RESET;
      else if (hit) cfg[p] <= wr_data;
    end
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int NUM_GROUPS = 4
) (
  input  logic [NUM_PINS-1:0][WORD_W-1:0]   cfg,
  input  logic [NUM_PINS-1:0]               level,
  input  logic [NUM_PINS-1:0]               level_prev,
  output logic [NUM_PINS-1:0]               evt,
  output logic [NUM_GROUPS-1:0][NUM_PINS-1:0] set_vec
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign evt[p] = trig_hit(cfg_mode(cfg[p]), level[p], level_prev[p]);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign set_vec[g][p] = evt[p] && (32'(cfg_group(cfg[p])) == g);
    end
  end
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
  parameter int NUM_PINS   = 32,
  parameter int NUM_GROUPS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_GROUPS-1:0][NUM_PINS-1:0] set_vec,
  input  logic [NUM_GROUPS-1:0][NUM_PINS-1:0] clr_vec,
  output logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend,
  output logic [NUM_GROUPS-1:0]               irq
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= '0;
        irq[g]  <= 1'b0;
      end else begin
        pend[g] <= (pend[g] & ~clr_vec[g]) | set_vec[g];
        irq[g]  <= |pend[g];
      end
    end
  end
endmodule

// File: rtl/gpio_grp_ctrl.sv
module gpio_grp_ctrl
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS   = 40,
  parameter int NUM_GROUPS = 4,
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32,
  localparam int ALT_W     = ALT_FUNCS * NUM_PINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  input  logic [ALT_W-1:0]      alt_out,
  input  logic [ALT_W-1:0]      alt_oe,
  output logic [ALT_W-1:0]      alt_in,
  output logic [NUM_GROUPS-1:0] irq_out
);
  // ---------------- address decode ----------------
  logic [8:0] cfg_idx;
  logic [4:0] pend_grp;
  logic [3:0] pend_word;
  logic       cfg_hit, pend_hit, cfg_wr, pend_wr;

  assign cfg_idx   = bus_addr[10:2];
  assign pend_grp  = bus_addr[10:6];
  assign pend_word = bus_addr[5:2];
  assign cfg_hit   = !bus_addr[11] && (bus_addr[1:0] == 2'b00) && (32'(cfg_idx) < NUM_PINS);
  assign pend_hit  = bus_addr[11] && (bus_addr[1:0] == 2'b00) &&
                     (32'(pend_grp) < NUM_GROUPS) && (32'(pend_word) < NUM_WORDS);
  assign cfg_wr    = bus_sel && bus_wr && cfg_hit;
  assign pend_wr   = bus_sel && bus_wr && pend_hit;

  // ---------------- state and event wires ----------------
  logic [NUM_PINS-1:0][WORD_W-1:0]     cfg_q;
  logic [NUM_PINS-1:0]                 lvl, lvl_prev, pin_evt;
  logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend_set, pend_clr, pend_q;

  gpio_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_in     (pad_in),
    .level      (lvl),
    .level_prev (lvl_prev)
  );

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_idx  (cfg_idx),
    .wr_data (bus_wdata),
    .cfg     (cfg_q)
  );

  gpio_trig_detect #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_trig (
    .cfg        (cfg_q),
    .level      (lvl),
    .level_prev (lvl_prev),
    .evt        (pin_evt),
    .set_vec    (pend_set)
  );

  // Acknowledge: one bit of the written word per pin of the addressed group/word.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_ack
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
      assign pend_clr[g][p] = pend_wr && (32'(pend_grp) == g) &&
                              (32'(pend_word) == p / 32) && bus_wdata[p % 32];
    end
  end

  gpio_pend_bank #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (pend_set),
    .clr_vec (pend_clr),
    .pend    (pend_q),
    .irq     (irq_out)
  );

  // ---------------- pad and peripheral routing ----------------
  logic [NUM_PINS-1:0][WORD_W-1:0] cfg_view;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    logic [1:0] fsel;
    logic       drive;
    assign fsel  = cfg_func(cfg_q[p]);
    assign drive = (cfg_mode(cfg_q[p]) == MODE_DRIVE);
    assign cfg_view[p] = {cfg_q[p][WORD_W-1:1], drive ? cfg_q[p][BIT_DATA] : lvl[p]};

    always_comb begin
      pad_out[p] = cfg_q[p][BIT_DATA];
      pad_oe[p]  = drive;
      for (int f = 1; f <= ALT_FUNCS; f++) begin
        if (32'(fsel) == f) begin
          pad_out[p] = alt_out[(f-1)*NUM_PINS + p];
          pad_oe[p]  = alt_oe[(f-1)*NUM_PINS + p];
        end
      end
    end

    for (genvar f = 1; f <= ALT_FUNCS; f++) begin : g_alt
      assign alt_in[(f-1)*NUM_PINS + p] = (32'(fsel) == f) && lvl[p];
    end
  end

  // ---------------- read path ----------------
  logic [WORD_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (cfg_hit) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (32'(cfg_idx) == p) rd_next = cfg_view[p];
    end else if (pend_hit) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int p = 0; p < NUM_PINS; p++)
          if ((32'(pend_grp) == g) && (32'(pend_word) == p / 32))
            rd_next[p % 32] = pend_q[g][p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_grp_chk.sv
module gpio_grp_chk
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS   = 40,
  parameter int NUM_GROUPS = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NUM_PINS-1:0][WORD_W-1:0]     cfg,
  input logic [NUM_PINS-1:0]                 evt,
  input logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend,
  input logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend_set,
  input logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend_clr,
  input logic [NUM_GROUPS-1:0]               irq_out
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    p_irq_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_out[g] == $past(|pend[g])));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr[g][p] && !pend_set[g][p]) |=> !pend[g][p]);
      p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set[g][p] |=> pend[g][p]);
      p_own_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set[g][p] |-> (32'(cfg_group(cfg[p])) == g));
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
    p_quiet_modes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode(cfg[p]) inside {MODE_RSVD, MODE_DRIVE, MODE_QUIET}) |-> !evt[p]);
    p_edge_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[p] && (cfg_mode(cfg[p]) inside {MODE_RISE, MODE_FALL}))
        |=> (!$stable(cfg[p][3:1]) || !evt[p]));
    p_lock_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_locked(cfg[p]) |=> $stable(cfg[p]));
  end
endmodule

bind gpio_grp_ctrl gpio_grp_chk #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg      (cfg_q),
  .evt      (pin_evt),
  .pend     (pend_q),
  .pend_set (pend_set),
  .pend_clr (pend_clr),
  .irq_out  (irq_out)
);

// File: tb/gpio_grp_ctrl_bench.sv
module gpio_grp_ctrl_bench;
  localparam int NP = 40;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [3*NP-1:0] alt_out = '0, alt_oe = '0;
  logic [3*NP-1:0] alt_in;
  logic [NG-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_grp_ctrl #(.NUM_PINS(NP), .NUM_GROUPS(NG)) u_gpio_grp_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq_out(irq_out)
  );

  function automatic logic [11:0] cfg_addr(input int p);
    return 12'(4 * p);
  endfunction

  function automatic logic [11:0] pend_addr(input int g, input int k);
    return 12'(12'h800 + 12'h40 * g + 4 * k);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(cfg_addr(0), d);  check("R1", "cfg0 reset", d, 32'h0000_000E);
    bus_read(cfg_addr(39), d); check("R1", "cfg39 reset", d, 32'h0000_000E);
    check("R1", "irq reset", 32'(irq_out), 32'h0);
    check("R1", "pad_oe reset", 32'(pad_oe[31:0]), 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    bus_write(cfg_addr(3), 32'h0000_0003);
    check("R2", "pad_oe3", 32'(pad_oe[3]), 32'h1);
    check("R2", "pad_out3 high", 32'(pad_out[3]), 32'h1);
    bus_read(cfg_addr(3), d); check("R2", "read drive 1", d, 32'h0000_0003);
    bus_write(cfg_addr(3), 32'h0000_0002);
    check("R2", "pad_out3 low", 32'(pad_out[3]), 32'h0);
    bus_read(cfg_addr(3), d); check("R2", "read drive 0", d, 32'h0000_0002);
  endtask

  task automatic t_input_live();
    logic [31:0] d;
    bus_write(cfg_addr(5), 32'h0000_000F);
    check("R3", "pad_oe5 off", 32'(pad_oe[5]), 32'h0);
    bus_read(cfg_addr(5), d); check("R3", "stored 1 hidden, pin 0", d, 32'h0000_000E);
    pad_in[5] = 1'b1; tick(4);
    bus_read(cfg_addr(5), d); check("R3", "live pin 1", d, 32'h0000_000F);
    bus_write(cfg_addr(5), 32'h0000_000E);
    bus_read(cfg_addr(5), d); check("R3", "stored 0 hidden, pin 1", d, 32'h0000_000F);
    pad_in[5] = 1'b0; tick(4);
  endtask

  task automatic t_periph();
    bus_write(cfg_addr(7), 32'h0000_004E);
    alt_out[NP + 7] = 1'b1; alt_oe[NP + 7] = 1'b1; tick(1);
    check("R4", "pad_out7 from function 2", 32'(pad_out[7]), 32'h1);
    check("R4", "pad_oe7 from function 2", 32'(pad_oe[7]), 32'h1);
    alt_oe[NP + 7] = 1'b0; tick(1);
    check("R4", "pad_oe7 follows alt_oe", 32'(pad_oe[7]), 32'h0);
    pad_in[7] = 1'b1; tick(4);
    check("R4", "alt_in f2", 32'(alt_in[NP + 7]), 32'h1);
    check("R4", "alt_in f1 unselected", 32'(alt_in[7]), 32'h0);
    check("R4", "alt_in f3 unselected", 32'(alt_in[2*NP + 7]), 32'h0);
    pad_in[7] = 1'b0; alt_out[NP + 7] = 1'b0;
    bus_write(cfg_addr(7), 32'h0000_000E);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    // pin 2, group 1, rising
    bus_write(cfg_addr(2), 32'h0001_0008);
    pad_in[2] = 1'b1; tick(6);
    bus_read(pend_addr(1, 0), d); check("R5", "rise pending", d, 32'h0000_0004);
    check("R11", "irq1 high", 32'(irq_out), 32'h2);
    bus_read(pend_addr(0, 0), d); check("R8", "group0 untouched", d, 32'h0);
    bus_write(pend_addr(1, 0), 32'h0);
    bus_read(pend_addr(1, 0), d); check("R10", "write 0 keeps bit", d, 32'h0000_0004);
    bus_write(pend_addr(1, 0), 32'h0000_0004);
    bus_read(pend_addr(1, 0), d); check("R10", "write 1 clears", d, 32'h0);
    tick(2);
    check("R11", "irq1 drops", 32'(irq_out), 32'h0);
    tick(4);
    bus_read(pend_addr(1, 0), d); check("R5", "steady high no re-trigger", d, 32'h0);
    pad_in[2] = 1'b0; tick(6);
    bus_read(pend_addr(1, 0), d); check("R5", "falling ignored in rise mode", d, 32'h0);
    // falling
    bus_write(cfg_addr(2), 32'h0001_000A);
    pad_in[2] = 1'b1; tick(6);
    bus_read(pend_addr(1, 0), d); check("R5", "rising ignored in fall mode", d, 32'h0);
    pad_in[2] = 1'b0; tick(6);
    bus_read(pend_addr(1, 0), d); check("R5", "fall pending", d, 32'h0000_0004);
    bus_write(pend_addr(1, 0), 32'h0000_0004);
    // both
    bus_write(cfg_addr(2), 32'h0001_000C);
    pad_in[2] = 1'b1; tick(6);
    bus_read(pend_addr(1, 0), d); check("R5", "both: rise", d, 32'h0000_0004);
    bus_write(pend_addr(1, 0), 32'h0000_0004);
    pad_in[2] = 1'b0; tick(6);
    bus_read(pend_addr(1, 0), d); check("R5", "both: fall", d, 32'h0000_0004);
    bus_write(pend_addr(1, 0), 32'h0000_0004);
    bus_write(cfg_addr(2), 32'h0000_000E);
  endtask

  task automatic t_level();
    logic [31:0] d;
    // pin 33 lives in word k=1: R9 address check
    bus_write(cfg_addr(33), 32'h0002_0004);
    pad_in[33] = 1'b1; tick(6);
    bus_read(pend_addr(2, 1), d); check("R9", "group2 word1 bit1", d, 32'h0000_0002);
    bus_read(pend_addr(2, 0), d); check("R9", "group2 word0 empty", d, 32'h0);
    check("R11", "irq2 high", 32'(irq_out), 32'h4);
    bus_write(pend_addr(2, 1), 32'h0000_0002);
    bus_read(pend_addr(2, 1), d); check("R6", "level held re-sets", d, 32'h0000_0002);
    pad_in[33] = 1'b0; tick(4);
    bus_write(pend_addr(2, 1), 32'h0000_0002);
    bus_read(pend_addr(2, 1), d); check("R6", "level gone clears", d, 32'h0);
    bus_write(cfg_addr(33), 32'h0002_0006);
    tick(2);
    bus_read(pend_addr(2, 1), d); check("R6", "low level pending", d, 32'h0000_0002);
    pad_in[33] = 1'b1; tick(4);
    bus_write(pend_addr(2, 1), 32'h0000_0002);
    bus_read(pend_addr(2, 1), d); check("R6", "low level gone clears", d, 32'h0);
    // masking
    bus_write(cfg_addr(33), 32'h0002_000E);
    pad_in[33] = 1'b0; tick(6);
    bus_read(pend_addr(2, 1), d); check("R7", "mode 7 masks", d, 32'h0);
    bus_write(cfg_addr(33), 32'h0002_0000);
    pad_in[33] = 1'b1; tick(6);
    bus_read(pend_addr(2, 1), d); check("R7", "mode 0 silent", d, 32'h0);
    bus_write(cfg_addr(33), 32'h0002_0002);
    pad_in[33] = 1'b0; tick(6);
    bus_read(pend_addr(2, 1), d); check("R7", "mode 1 silent", d, 32'h0);
    check("R7", "no irq", 32'(irq_out), 32'h0);
    bus_write(cfg_addr(33), 32'h0000_000E);
  endtask

  task automatic t_group_range();
    logic [31:0] d;
    bus_write(cfg_addr(4), 32'h0005_0008);
    pad_in[4] = 1'b1; tick(6);
    for (int g = 0; g < NG; g++) begin
      bus_read(pend_addr(g, 0), d);
      check("R8", "group 5 records nowhere", d, 32'h0);
    end
    check("R8", "no irq for group 5", 32'(irq_out), 32'h0);
    pad_in[4] = 1'b0;
    bus_write(cfg_addr(4), 32'h0000_000E);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    bus_write(cfg_addr(10), 32'h00C7_8F8E);
    bus_read(cfg_addr(10), d); check("R13", "fields read back", d, 32'h00C7_8F8E);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_write(cfg_addr(9), 32'h0020_0003);
    check("R12", "locked drives 1", 32'(pad_out[9]), 32'h1);
    bus_write(cfg_addr(9), 32'h0000_000E);
    bus_read(cfg_addr(9), d); check("R12", "write ignored", d, 32'h0020_0003);
    check("R12", "pad_oe9 still on", 32'(pad_oe[9]), 32'h1);
    do_reset();
    bus_read(cfg_addr(9), d); check("R12", "reset releases lock", d, 32'h0000_000E);
    bus_write(cfg_addr(9), 32'h0000_0003);
    bus_read(cfg_addr(9), d); check("R12", "writable after reset", d, 32'h0000_0003);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_output();
    t_input_live();
    t_periph();
    t_edges();
    t_level();
    t_group_range();
    t_fields();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule